// File: doc/BRIEF.md
# Fractional-Increment System Time Counter

This block holds a 64-bit fixed-point time value that advances by a programmable increment on every cycle of the timing oscillator, signalled by a one-cycle `tick` strobe. The fraction sits in the low bits of the word, so software turns the value into nanoseconds with a plain right shift. Software trims the clock's frequency by rewriting the increment. Examples: at a 6.4 ns tick the nominal increment is 0x66666666 with a 28-bit fraction. At 1G (64 ns) it is 0x40000000 with a 24-bit fraction. At 100M (640 ns) it is 0x50000000 with a 21-bit fraction. The narrow variant uses values and fraction widths that are 7 bits smaller.

Software reaches the block through a small word-wide register port. Address 0 is the low time word, address 1 is the high time word and address 2 is the increment. A read of the low word captures the high word into a shadow copy, so that reading the low word and then the high word gives one consistent 64-bit sample. A write to the low word is only staged. The following write to the high word loads both halves in a single cycle. Writing zero to both halves clears the time.

The parameter `NARROW` selects the increment layout. With `NARROW=0` the increment field is 31 bits wide. With `NARROW=1` the field is 24 bits wide, and bit 24 is an enable for the increment period that software sets to 1.

Top module: `systime_accum`

## Requirements
- R1: While `rst_n` is low at a clock edge, the time value, the increment, the staged low word, the shadow and `reg_rdata` all clear to zero at that edge.
- R2: On a clock edge with `tick` high and no high-word write, `time_o` becomes its previous value plus the effective increment. With `tick` low and no high-word write, `time_o` holds its value.
- R3: With `NARROW=0`, the increment register keeps write bits [30:0]. Bit 31 always reads back as 0, and the effective increment equals the register.
- R4: With `NARROW=1`, the increment register keeps bits [23:0] (the increment) and bit 24 (the period enable), and all higher bits read back as 0. When bit 24 is 1, a tick adds bits [23:0]. When bit 24 is 0, a tick adds nothing.
- R5: A write to the increment (address 2) takes effect from the next edge. A tick in the same cycle as the write still adds the old increment.
- R6: A write to address 0 only stages the word and leaves `time_o` unchanged. A write to address 1 sets `time_o` to {written word, staged word} at that edge, and this takes precedence over a tick in the same cycle.
- R7: A read of address 0 returns the low time word as it stood before the edge and copies the high word into the shadow. A later read of address 1 returns that shadow, even if the live time has moved on since.
- R8: The time value wraps modulo 2^64 with no saturation.
- R9: `reg_rdata` changes only on the edge after a read strobe and otherwise holds its value. A read of address 2 returns the increment register, and a read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle strobe for each oscillator period |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 time low, 1 time high, 2 increment |
| reg_wdata | input | WORD_W | Write data |
| reg_rdata | output | WORD_W | Read data, valid on the edge after `reg_rd` |
| time_o | output | 2*WORD_W | Live time value |

## Verification
The bench elaborates two copies of the block with `WORD_W=32`: one with `NARROW=0` and one with `NARROW=1`. The wide copy runs through the vector table and directed cases that reach the 64-bit wrap, load-over-tick precedence and a stale shadow read after a carry into the high word. The narrow copy covers masking of bits above the period field and the frozen count when the period bit is clear.

// File: rtl/systime_pkg.sv
// Shared definitions for the fractional-increment time counter.
// Assumes a word-wide register port with a 2-bit address.
package systime_pkg;
    typedef enum logic [1:0] {
        SEL_TLO  = 2'd0,
        SEL_THI  = 2'd1,
        SEL_INC  = 2'd2,
        SEL_NONE = 2'd3
    } st_sel_e;

    localparam int WIDE_FIELD_W   = 31;
    localparam int NARROW_FIELD_W = 24;
endpackage

// File: rtl/st_incr_reg.sv
// Increment register: stores the masked write value and derives the
// increment actually applied per tick. Assumes WORD_W > 25.
module st_incr_reg #(
    parameter int WORD_W = 32,
    parameter bit NARROW = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] inc_q,
    output logic [WORD_W-1:0] inc_eff
);
    import systime_pkg::*;

    localparam int KEEP_W = NARROW ? NARROW_FIELD_W + 1 : WIDE_FIELD_W;
    localparam logic [WORD_W-1:0] KEEP_MASK = WORD_W'((64'd1 << KEEP_W) - 64'd1);

    // Capture software writes, dropping bits outside the kept layout.
    always_ff @(posedge clk) begin
        if (!rst_n)     inc_q <= '0;
        else if (wr_en) inc_q <= wdata & KEEP_MASK;
    end

    generate
        if (NARROW) begin : g_narrow
            // Period bit gates the 24-bit field.
            assign inc_eff = inc_q[NARROW_FIELD_W]
                           ? {{(WORD_W-NARROW_FIELD_W){1'b0}}, inc_q[NARROW_FIELD_W-1:0]}
                           : '0;
        end else begin : g_wide
            // Whole register is the increment.
            assign inc_eff = inc_q;
        end
    endgenerate
endmodule

// File: rtl/st_accum.sv
// Time accumulator: adds the increment on each tick, or loads a full
// value (load wins over tick). Wraps modulo 2^(2*WORD_W).
module st_accum #(
    parameter int WORD_W = 32,
    localparam int TW    = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [TW-1:0]     load_val,
    input  logic [WORD_W-1:0] inc,
    output logic [TW-1:0]     time_q
);
    // Update time by load, tick increment, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     time_q <= '0;
        else if (load)  time_q <= load_val;
        else if (tick)  time_q <= time_q + {{WORD_W{1'b0}}, inc};
    end
endmodule

// File: rtl/st_rd_port.sv
// Read port: registered read data, with a shadow of the high word
// captured on every low-word read for coherent 64-bit reads.
module st_rd_port #(
    parameter int WORD_W = 32,
    localparam int TW    = 2 * WORD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  systime_pkg::st_sel_e sel,
    input  logic [TW-1:0]        time_q,
    input  logic [WORD_W-1:0]    inc_q,
    output logic [WORD_W-1:0]    rdata,
    output logic [WORD_W-1:0]    shadow_q
);
    import systime_pkg::*;

    // Register the selected word; low read also fills the shadow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            shadow_q <= '0;
        end else if (rd_en) begin
            case (sel)
                SEL_TLO: begin
                    rdata    <= time_q[WORD_W-1:0];
                    shadow_q <= time_q[TW-1:WORD_W];
                end
                SEL_THI: rdata <= shadow_q;
                SEL_INC: rdata <= inc_q;
                default: rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/systime_accum.sv
// Top of the fractional-increment system time counter. Decodes the
// register port, stages the low word for atomic loads, and ties the
// increment register, accumulator and read port together.
module systime_accum #(
    parameter int WORD_W = 32,
    parameter bit NARROW = 1'b0,
    localparam int TW    = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic [TW-1:0]     time_o
);
    import systime_pkg::*;

    st_sel_e           sel;
    logic [WORD_W-1:0] stage_q;
    logic [WORD_W-1:0] inc_q;
    logic [WORD_W-1:0] inc_eff;
    logic [WORD_W-1:0] shadow_q;
    logic              load;

    assign sel  = st_sel_e'(reg_addr);
    assign load = reg_wr && (sel == SEL_THI);

    // Hold the low word until the high word completes the load.
    always_ff @(posedge clk) begin
        if (!rst_n)                          stage_q <= '0;
        else if (reg_wr && sel == SEL_TLO)   stage_q <= reg_wdata;
    end

    st_incr_reg #(.WORD_W(WORD_W), .NARROW(NARROW)) u_inc (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr && sel == SEL_INC),
        .wdata   (reg_wdata),
        .inc_q   (inc_q),
        .inc_eff (inc_eff)
    );

    st_accum #(.WORD_W(WORD_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (load),
        .load_val ({reg_wdata, stage_q}),
        .inc      (inc_eff),
        .time_q   (time_o)
    );

    st_rd_port #(.WORD_W(WORD_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (reg_rd),
        .sel      (sel),
        .time_q   (time_o),
        .inc_q    (inc_q),
        .rdata    (reg_rdata),
        .shadow_q (shadow_q)
    );
endmodule

// File: rtl/systime_accum_chk.sv
// Property checker for systime_accum, attached with bind below.
module systime_accum_chk #(
    parameter int WORD_W = 32,
    parameter bit NARROW = 1'b0,
    localparam int TW    = 2 * WORD_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [1:0]        reg_addr,
    input logic [WORD_W-1:0] reg_wdata,
    input logic [WORD_W-1:0] reg_rdata,
    input logic [TW-1:0]     time_o,
    input logic [WORD_W-1:0] inc_eff,
    input logic [WORD_W-1:0] shadow_q
);
    localparam int KEEP_W = NARROW ? 25 : 31;
    localparam logic [WORD_W-1:0] KEEP_MASK = WORD_W'((64'd1 << KEEP_W) - 64'd1);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (time_o == '0 && reg_rdata == '0)); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !(reg_wr && reg_addr == 2'd1)) |=> $stable(time_o)); // R2
    AST_TICK_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(reg_wr && reg_addr == 2'd1))
        |=> time_o == $past(time_o) + {{WORD_W{1'b0}}, $past(inc_eff)}); // R2
    AST_LOAD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1) |=> time_o[TW-1:WORD_W] == $past(reg_wdata)); // R6
    AST_SHADOW_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd1) |=> reg_rdata == $past(shadow_q)); // R7
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata)); // R9
    AST_INC_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd2) |=> (reg_rdata & ~KEEP_MASK) == '0); // R3
endmodule

bind systime_accum systime_accum_chk #(.WORD_W(WORD_W), .NARROW(NARROW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .time_o    (time_o),
    .inc_eff   (inc_eff),
    .shadow_q  (shadow_q)
);

// File: tb/test_systime_accum.sv
module test_systime_accum;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 32;
    localparam int NV = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // wide instance
    logic          tick, wr, rd;
    logic [1:0]    addr;
    logic [W-1:0]  wdata, rdata;
    logic [2*W-1:0] time_o;
    // narrow instance
    logic          n_tick, n_wr, n_rd;
    logic [1:0]    n_addr;
    logic [W-1:0]  n_wdata, n_rdata;
    logic [2*W-1:0] n_time;

    systime_accum #(.WORD_W(W), .NARROW(1'b0)) i_systime_accum (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(wr), .reg_rd(rd),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .time_o(time_o));

    systime_accum #(.WORD_W(W), .NARROW(1'b1)) i_systime_accum_nar (
        .clk(clk), .rst_n(rst_n), .tick(n_tick), .reg_wr(n_wr), .reg_rd(n_rd),
        .reg_addr(n_addr), .reg_wdata(n_wdata), .reg_rdata(n_rdata), .time_o(n_time));

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model of the wide instance, built from the requirements
    logic [2*W-1:0] m_time;
    logic [W-1:0]   m_inc, m_stage, m_sh, m_rd;

    // vector fields: {tick, wr, rd, addr[1:0], data[31:0]}
    localparam logic [36:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b0, 2'd2, 32'h66666666},  // R5 set increment
        {1'b1, 1'b0, 1'b0, 2'd0, 32'h0},         // R2 tick
        {1'b1, 1'b0, 1'b0, 2'd0, 32'h0},         // R2 tick
        {1'b1, 1'b0, 1'b1, 2'd0, 32'h0},         // R7 read low with tick
        {1'b0, 1'b0, 1'b1, 2'd1, 32'h0},         // R7 read high
        {1'b1, 1'b1, 1'b0, 2'd0, 32'h12345678},  // R6 stage only
        {1'b1, 1'b0, 1'b0, 2'd0, 32'h0},         // R2 tick
        {1'b1, 1'b1, 1'b0, 2'd1, 32'h0000ABCD},  // R6 load beats tick
        {1'b0, 1'b0, 1'b1, 2'd0, 32'h0},         // R7 read low
        {1'b1, 1'b1, 1'b0, 2'd2, 32'hFFFFFFFF},  // R5 old increment used
        {1'b0, 1'b0, 1'b1, 2'd2, 32'h0},         // R3 readback masked
        {1'b1, 1'b0, 1'b1, 2'd3, 32'h0}          // R9 unused address
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one wide-instance operation for one cycle and check against the model.
    task automatic step(input logic t, input logic w, input logic r,
                        input logic [1:0] a, input logic [W-1:0] d, input string req);
        logic [2*W-1:0] nt;
        tick = t; wr = w; rd = r; addr = a; wdata = d;
        nt = m_time;
        if (w && a == 2'd1)  nt = {d, m_stage};
        else if (t)          nt = m_time + {32'h0, m_inc};
        if (r) begin
            case (a)
                2'd0: begin m_rd = m_time[W-1:0]; m_sh = m_time[2*W-1:W]; end
                2'd1: m_rd = m_sh;
                2'd2: m_rd = m_inc;
                default: m_rd = '0;
            endcase
        end
        if (w && a == 2'd0) m_stage = d;
        if (w && a == 2'd2) m_inc = d & 32'h7FFFFFFF;
        m_time = nt;
        @(negedge clk);
        tick = 0; wr = 0; rd = 0;
        chk({req, " time"}, time_o, m_time);
        chk({req, " rdata"}, {32'h0, rdata}, {32'h0, m_rd});
    endtask

    task automatic nstep(input logic t, input logic w, input logic r,
                         input logic [1:0] a, input logic [W-1:0] d);
        n_tick = t; n_wr = w; n_rd = r; n_addr = a; n_wdata = d;
        @(negedge clk);
        n_tick = 0; n_wr = 0; n_rd = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick = 0; wr = 0; rd = 0; addr = 0; wdata = 0;
        n_tick = 0; n_wr = 0; n_rd = 0; n_addr = 0; n_wdata = 0;
        m_time = '0; m_inc = '0; m_stage = '0; m_sh = '0; m_rd = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 time", time_o, 64'h0);
        chk("R1 rdata", {32'h0, rdata}, 64'h0);
        chk("R1 narrow time", n_time, 64'h0);
        rst_n = 1'b1;
        step(1, 0, 1, 2'd2, 0, "R1 incr after reset");
        step(0, 0, 0, 2'd0, 0, "R2 idle hold");

        for (int i = 0; i < NV; i++)
            step(VEC[i][36], VEC[i][35], VEC[i][34], VEC[i][33:32], VEC[i][31:0], "R2/R5/R6/R7 vector");

        // R9: read data holds while no read strobe
        step(1, 0, 0, 2'd0, 0, "R9 hold");
        chk("R9 rdata unused addr", {32'h0, rdata}, 64'h0);

        // R8: wrap past 2^64
        step(0, 1, 0, 2'd0, 32'hFFFFFFF0, "R6 stage");
        step(0, 1, 0, 2'd1, 32'hFFFFFFFF, "R6 load");
        step(0, 1, 0, 2'd2, 32'h20, "R5 incr");
        step(1, 0, 0, 2'd0, 0, "R8 wrap");
        chk("R8 wrapped value", time_o, 64'h10);

        // R7: stale shadow after carry into the high word
        step(0, 1, 0, 2'd0, 32'hFFFFFFFF, "R6 stage");
        step(0, 1, 0, 2'd1, 32'h0, "R6 load");
        step(0, 1, 0, 2'd2, 32'h1, "R5 incr");
        step(0, 0, 1, 2'd0, 0, "R7 low");
        chk("R7 low word", {32'h0, rdata}, 64'hFFFFFFFF);
        step(1, 0, 0, 2'd0, 0, "R2 carry");
        chk("R8 carry", time_o, 64'h1_00000000);
        step(0, 0, 1, 2'd1, 0, "R7 stale");
        chk("R7 stale shadow", {32'h0, rdata}, 64'h0);
        step(0, 0, 1, 2'd0, 0, "R7 low again");
        step(0, 0, 1, 2'd1, 0, "R7 fresh");
        chk("R7 fresh shadow", {32'h0, rdata}, 64'h1);

        // R4: narrow layout
        nstep(0, 1, 0, 2'd2, 32'hFFFFFFFF);
        nstep(0, 0, 1, 2'd2, 0);
        chk("R4 narrow readback", {32'h0, n_rdata}, 64'h01FFFFFF);
        nstep(1, 0, 0, 2'd0, 0);
        chk("R4 narrow tick", n_time, 64'h00FFFFFF);
        nstep(0, 1, 0, 2'd2, 32'h00000005);
        nstep(1, 0, 0, 2'd0, 0);
        nstep(1, 0, 0, 2'd0, 0);
        chk("R4 period clear freezes", n_time, 64'h00FFFFFF);
        nstep(0, 1, 0, 2'd2, 32'h01000003);
        nstep(1, 0, 0, 2'd0, 0);
        chk("R4 period set adds", n_time, 64'h01000002);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule